// File: doc/BRIEF.md
# Execution Port Dispatcher

This block sits between a scheduler and eight execution ports. In each cycle it receives a group of up to four ready micro-ops, listed oldest first. Each micro-op has an operation class and a tag. The block binds each micro-op to one eligible port, under an asymmetric capability map. When a micro-op can use more than one port, it takes the most specialised free port first. This leaves the broad ports open for younger micro-ops. A valid micro-op that finds no eligible port still free is flagged as stalled in the same cycle, so the scheduler can hold it for a later cycle.

For each port the block reports whether something was bound to it, the lane index of that micro-op, its tag, and a gate enable. The gate enable lets an idle unit be switched off for the cycle. The two main math ports also track fused multiply-add issues in a short shift window. Each such port raises a completion strobe a fixed five cycles after every fused multiply-add it accepts. Back-to-back fused multiply-adds on the same port are accepted every cycle.

Top module: `uop_port_dispatch`

## Requirements
- R1: The class code is 3 bits: 0 integer ALU, 1 branch, 2 load, 3 store-address, 4 store-data, 5 fused multiply-add, 6 floating-point multiply, 7 vector ALU. Each port takes at most one micro-op per cycle. When port p is bound, `port_idx[2p+1:2p]` holds the lane and `port_tag[6p+5:6p]` holds that lane's tag. Lane l's class is `in_cls[3l+2:3l]` and its tag is `in_tag[6l+5:6l]`.
- R2: Lanes are served in order, lane 0 first. A younger lane only sees the ports that the older lanes left free.
- R3: A branch goes to port 6 when that port is free, otherwise to port 0. It is never bound to port 5 or to any other port.
- R4: An integer ALU micro-op tries ports 6, 5, 0 and 1, in that order.
- R5: A load goes to port 2, otherwise to port 3. It is never bound to port 7.
- R6: A store-address micro-op tries port 7, then port 2, then port 3.
- R7: Port 4 accepts store-data micro-ops and nothing else, and store-data uses no other port.
- R8: Fused multiply-add and floating-point multiply micro-ops issue on port 0, otherwise on port 1. A vector ALU micro-op tries port 5, then port 0, then port 1. A branch or integer micro-op can still issue on port 6 in the same cycle that port 0 takes floating-point work.
- R9: `stall[l]` is high in the same cycle when lane l is valid and none of its eligible ports is free. An invalid lane is never bound and never stalls.
- R10: `fma_done[q]` (q = 0 or 1) is high in exactly the fifth cycle after a cycle in which a fused multiply-add was bound to port q. Issues in consecutive cycles each produce their own strobe.
- R11: `gate_en[p]` is high only in cycles in which port p is bound. An idle port also shows zero index and zero tag.
- R12: Reset empties both fused multiply-add windows, so an issue made before reset never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Valid bit per lane, lane 0 oldest |
| in_cls | input | 12 | 3-bit class code per lane |
| in_tag | input | 24 | 6-bit tag per lane |
| port_valid | output | 8 | Port bound this cycle |
| port_idx | output | 16 | 2-bit lane index per port |
| port_tag | output | 48 | Tag of the bound micro-op per port |
| gate_en | output | 8 | Unit power enable per port |
| stall | output | 4 | Lane valid but not bound |
| fma_done | output | 2 | Fused multiply-add completion for ports 0 and 1 |

## Verification
The binding path has no state, so a wrong link in the free-port chain shows at the ports in the same cycle. It appears as a port taken twice, a lane moved onto a broader port, or a stall bit that does not match the free ports. The only state is the pair of fused multiply-add windows. A dropped, shifted or stuck bit there shows up as a completion strobe missing, early, late or repeated. This becomes visible five cycles after the issue that feeds it, or after the first reset that fails to clear it. The bench therefore keeps its own five-deep issue history. It compares the strobes on every cycle, including cycles with back-to-back issues on both math ports.

// File: rtl/upd_pkg.sv
package upd_pkg;

  localparam int NPORT      = 8;
  localparam int CLS_W      = 3;
  localparam int MAX_CHOICE = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_IALU = 3'd0,
    CL_BR   = 3'd1,
    CL_LD   = 3'd2,
    CL_STA  = 3'd3,
    CL_STD  = 3'd4,
    CL_FMA  = 3'd5,
    CL_FMUL = 3'd6,
    CL_VALU = 3'd7
  } op_class_e;

  // Returns {usable, port} for the given preference rank; rank 0 is the
  // narrowest port that can still take the class.
  function automatic logic [3:0] port_choice(op_class_e c, int unsigned rank);
    logic [15:0] lst;
    case (c)
      CL_IALU: lst = {4'h9, 4'h8, 4'hD, 4'hE};
      CL_BR:   lst = {4'h0, 4'h0, 4'h8, 4'hE};
      CL_LD:   lst = {4'h0, 4'h0, 4'hB, 4'hA};
      CL_STA:  lst = {4'h0, 4'hB, 4'hA, 4'hF};
      CL_STD:  lst = {4'h0, 4'h0, 4'h0, 4'hC};
      CL_FMA:  lst = {4'h0, 4'h0, 4'h9, 4'h8};
      CL_FMUL: lst = {4'h0, 4'h0, 4'h9, 4'h8};
      default: lst = {4'h0, 4'h9, 4'h8, 4'hD};
    endcase
    return lst[rank*4 +: 4];
  endfunction

endpackage

// File: rtl/upd_port_pick.sv
module upd_port_pick
  import upd_pkg::*;
(
  input  logic             op_valid,
  input  op_class_e        op_cls,
  input  logic [NPORT-1:0] free_in,
  output logic [NPORT-1:0] grant
);

  logic [3:0] ent;

  // Walk from the widest choice down so the narrowest free port wins.
  always_comb begin
    grant = '0;
    ent   = '0;
    if (op_valid) begin
      for (int r = MAX_CHOICE - 1; r >= 0; r--) begin
        ent = port_choice(op_cls, unsigned'(r));
        if (ent[3] && free_in[ent[2:0]]) begin
          grant             = '0;
          grant[ent[2:0]]   = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/upd_fma_window.sv
module upd_fma_window #(
  parameter int LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic done
);

  localparam int CW = $clog2(LAT + 2);

  logic [LAT-1:0] sr_q, sr_d;
  logic           sr_en;

  always_comb begin
    sr_d  = {sr_q[LAT-2:0], issue};
    sr_en = issue | (|sr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign done = sr_q[LAT-1];

  // In-flight counter kept only for the checks below.
  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_q + CW'(issue) - CW'(done);
  end

  a_r10_strobe_has_issue: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inflight_q != '0));
  a_r10_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CW'(LAT));
  a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q == '0) |-> !done);

endmodule

// File: rtl/uop_port_dispatch.sv
module uop_port_dispatch
  import upd_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int TAG_W   = 6,
  parameter int FMA_LAT = 5,
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES*CLS_W-1:0] in_cls,
  input  logic [LANES*TAG_W-1:0] in_tag,
  output logic [NPORT-1:0]       port_valid,
  output logic [NPORT*IDX_W-1:0] port_idx,
  output logic [NPORT*TAG_W-1:0] port_tag,
  output logic [NPORT-1:0]       gate_en,
  output logic [LANES-1:0]       stall,
  output logic [1:0]             fma_done
);

  op_class_e        cls   [LANES];
  logic [NPORT-1:0] grant [LANES];
  logic [NPORT-1:0] free_c[LANES+1];
  logic [CLS_W-1:0] pcls  [NPORT];

  assign free_c[0] = '1;

  // Oldest-first chain: each lane sees only what older lanes left.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cls[l] = op_class_e'(in_cls[l*CLS_W +: CLS_W]);

    upd_port_pick u_pick (
      .op_valid (in_valid[l]),
      .op_cls   (cls[l]),
      .free_in  (free_c[l]),
      .grant    (grant[l])
    );

    assign free_c[l+1] = free_c[l] & ~grant[l];
    assign stall[l]    = in_valid[l] & ~(|grant[l]);

    a_r9_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[l] |-> (grant[l] == '0 && !stall[l]));
    a_r1_one_port_per_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[l]));
    a_r3_branch_not_p5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[l] && cls[l] == CL_BR) |-> !grant[l][5]);
    a_r5_load_not_p7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[l] && cls[l] == CL_LD) |-> !grant[l][7]);
    a_r8_mul_on_math: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[l] && (cls[l] == CL_FMA || cls[l] == CL_FMUL))
        |-> (grant[l][NPORT-1:2] == '0));
  end

  // Per-port output mux.
  always_comb begin
    port_valid = '0;
    port_idx   = '0;
    port_tag   = '0;
    for (int p = 0; p < NPORT; p++) begin
      pcls[p] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (grant[l][p]) begin
          port_valid[p]               = 1'b1;
          port_idx[p*IDX_W +: IDX_W]  = IDX_W'(l);
          port_tag[p*TAG_W +: TAG_W]  = in_tag[l*TAG_W +: TAG_W];
          pcls[p]                     = in_cls[l*CLS_W +: CLS_W];
        end
      end
    end
  end

  assign gate_en = port_valid;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [LANES-1:0] hits;
    for (genvar l = 0; l < LANES; l++) begin : g_hit
      assign hits[l] = grant[l][p];
    end
    a_r1_port_once: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hits) <= 1);
  end

  a_r7_p4_std_only: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid[4] |-> (pcls[4] == CL_STD));

  // Fused multiply-add windows on the two main math ports.
  for (genvar q = 0; q < 2; q++) begin : g_fma
    logic fma_issue;
    assign fma_issue = port_valid[q] && (pcls[q] == CL_FMA);

    upd_fma_window #(.LAT(FMA_LAT)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (fma_issue),
      .done  (fma_done[q])
    );
  end

endmodule

// File: tb/uop_port_dispatch_bench.sv
module uop_port_dispatch_bench;

  localparam logic [2:0] IALU = 3'd0, BR = 3'd1, LD = 3'd2, STA = 3'd3,
                         STD = 3'd4, FMA = 3'd5, FMUL = 3'd6, VALU = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  in_valid;
  logic [11:0] in_cls;
  logic [23:0] in_tag;
  logic [7:0]  port_valid;
  logic [15:0] port_idx;
  logic [47:0] port_tag;
  logic [7:0]  gate_en;
  logic [3:0]  stall;
  logic [1:0]  fma_done;

  uop_port_dispatch u_uop_port_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_tag(in_tag), .port_valid(port_valid), .port_idx(port_idx),
    .port_tag(port_tag), .gate_en(gate_en), .stall(stall), .fma_done(fma_done)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  pv;
    logic [15:0] ix;
    logic [47:0] tg;
    logic [3:0]  st;
    logic [1:0]  dn;
  } exp_t;

  exp_t  exp_q[$];
  string lbl_q[$];
  int    nchk = 0;
  int    nfail = 0;
  int    cyc = 0;
  logic [1:0] hist [8];

  // Preference per class, from the requirements; -1 = no further choice.
  int ptab [8][4] = '{
    '{6, 5, 0, 1}, '{6, 0, -1, -1}, '{2, 3, -1, -1}, '{7, 2, 3, -1},
    '{4, -1, -1, -1}, '{0, 1, -1, -1}, '{0, 1, -1, -1}, '{5, 0, 1, -1}};

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 8; i++) hist[i] = 2'b00;
  endtask

  // Driver: computes expectations and pushes them to the scoreboard.
  task automatic apply(input string req, input logic [3:0] v, input logic [11:0] c);
    logic [7:0]  busy;
    exp_t        e;
    logic [23:0] tg;
    logic [1:0]  fi;
    tg = 24'($urandom);
    busy = '0; e = '0; fi = '0;
    for (int l = 0; l < 4; l++) begin
      if (v[l]) begin
        int cl;
        bit got;
        cl  = int'(c[l*3 +: 3]);
        got = 1'b0;
        for (int r = 0; r < 4; r++) begin
          int p;
          p = ptab[cl][r];
          if (!got && p >= 0 && !busy[p]) begin
            busy[p] = 1'b1;
            got     = 1'b1;
            e.pv[p] = 1'b1;
            e.ix[p*2 +: 2] = 2'(l);
            e.tg[p*6 +: 6] = tg[l*6 +: 6];
            if (cl == 5 && p < 2) fi[p] = 1'b1;
          end
        end
        if (!got) e.st[l] = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = v; in_cls = c; in_tag = tg;
    e.dn = hist[(cyc + 3) % 8];
    hist[cyc % 8] = fi;
    cyc++;
    exp_q.push_back(e);
    lbl_q.push_back(req);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) apply(req, 4'b0000, 12'h000);
  endtask

  // Monitor: pops and compares away from the clock edge.
  always @(negedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string r;
      e = exp_q.pop_front();
      r = lbl_q.pop_front();
      check({r, " port_valid"}, 64'(port_valid), 64'(e.pv));
      check({r, " R1 port_idx"}, 64'(port_idx), 64'(e.ix));
      check({r, " R1 port_tag"}, 64'(port_tag), 64'(e.tg));
      check({r, " R9 stall"}, 64'(stall), 64'(e.st));
      check({r, " R11 gate_en"}, 64'(gate_en), 64'(e.pv));
      check({r, " R10 fma_done"}, 64'(fma_done), 64'(e.dn));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; in_cls = '0; in_tag = '0;
    @(negedge clk);
    #3;
    check("R12 reset fma_done", 64'(fma_done), 64'h0);
    check("R11 reset gate_en", 64'(gate_en), 64'h0);
    check("R9 reset stall", 64'(stall), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_hist();
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_cls = '0; in_tag = '0;
    clear_hist();
    do_reset();

    apply("R4 int order",      4'b1111, {IALU, IALU, IALU, IALU});
    apply("R3 branch pair",    4'b0111, {IALU, IALU, BR, BR});
    apply("R3 branch overflow",4'b0111, {BR, BR, BR, BR});
    apply("R5 loads",          4'b0111, {IALU, LD, LD, LD});
    apply("R6 store addr",     4'b1111, {STA, STA, STA, STA});
    apply("R7 store data",     4'b0111, {IALU, STD, STD, STA});
    apply("R8 mul class",      4'b0111, {IALU, FMUL, FMA, FMA});
    apply("R8 fp plus branch", 4'b0111, {IALU, IALU, BR, FMA});
    apply("R2 lane order",     4'b0111, {IALU, IALU, IALU, VALU});
    apply("R2 vector spill",   4'b1111, {IALU, VALU, VALU, VALU});
    apply("R9 invalid lanes",  4'b0101, {BR, LD, BR, LD});
    apply("R5 mixed mem",      4'b1111, {STD, LD, STA, LD});
    idle("R10 drain", 6);

    apply("R10 burst", 4'b0011, {IALU, IALU, FMA, FMA});
    apply("R10 burst", 4'b0001, {IALU, IALU, IALU, FMA});
    apply("R10 burst", 4'b0011, {IALU, IALU, FMA, FMA});
    apply("R10 burst", 4'b0110, {IALU, FMA, FMA, IALU});
    idle("R10 strobes", 7);

    apply("R12 pre-reset issue", 4'b0011, {IALU, IALU, FMA, FMA});
    idle("R12 pre-reset idle", 1);
    do_reset();
    idle("R12 no stale strobe", 7);

    for (int i = 0; i < 300; i++)
      apply("R2 mix", 4'($urandom), 12'($urandom));
    idle("R10 final drain", 7);

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule